// File: doc/BRIEF.md
# Conversion Result Serial Readout with Offset Correction

This block sits after the counter and sign logic of an integrating converter and hands each finished result to a host over a four-wire SPI-style link. Each result arrives as a 14-bit magnitude, a sign flag and an overrange flag on a valid/ready stream. The block turns it into a signed number and subtracts an offset that the host programmed. The difference is clamped to the signed range. The corrected 16-bit word is then placed in a shift register whose least-significant bit appears on the data output straight away.

The host reads a word with 16 serial clock pulses while chip select is low. Every falling edge moves the next bit onto the data line. After the sixteenth, the block pulses `read_done` and becomes ready for the next result. If the host lifts chip select early, the read is abandoned and the same word is served again from its first bit. A frame that the host runs while no word is waiting is treated as an offset write: 16 bits are taken from the host's data line, least-significant first.

The serial clock, chip select and host data are asynchronous to `clk`. Each one passes through a synchroniser, and its edges are detected in the `clk` domain. Each serial clock level must therefore last at least four `clk` cycles.

Top module: `adc_spi_readout`

## Requirements
- R1: The output word has this layout. Bits 14..0 hold the two's-complement value (result − offset), with bit 14 as the sign. The result is +magnitude when `res_neg`=0 and −magnitude when `res_neg`=1. Bit 15 is `res_ovr` OR'd with the saturation flag.
- R2: A result is accepted in the cycle where `res_valid` and `res_ready` are both high. From the next cycle on, and before any serial clock edge, `spi_miso` shows bit 0 of the corrected word.
- R3: Each synchronised falling edge of `spi_sck` while `spi_cs_n` is low moves the next higher bit onto `spi_miso`. After the 16th falling edge, `read_done` is high for exactly one cycle and the word is released.
- R4: A difference above +16383 is replaced by +16383, and one below −16384 is replaced by −16384. In both cases bit 15 is set.
- R5: `res_ready` is high only while no word is held and the synchronised chip select is inactive. While it is low, a source must hold `res_valid` and its data steady. It stays low from acceptance until the word has been fully read.
- R6: A frame run while no word is held is an offset write. `spi_mosi` is sampled on each rising serial clock edge, least-significant bit first. The 16 bits form a signed offset that takes effect on the 16th rising edge. A frame cut short leaves the offset unchanged. A frame run while a word is held never changes the offset.
- R7: If chip select is released before the 16th falling edge, the word is restored in full. The next frame starts again at bit 0, and `read_done` does not pulse.
- R8: After reset, `spi_miso` and `read_done` are 0, `res_ready` is 1 and the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result is offered |
| res_ready | output | 1 | Block can accept a result |
| res_mag | input | 14 | Result magnitude |
| res_neg | input | 1 | Result is negative |
| res_ovr | input | 1 | Converter overrange flag |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_mosi | input | 1 | Serial data from host (offset writes) |
| spi_miso | output | 1 | Serial data to host, LSB first |
| read_done | output | 1 | One-cycle pulse after a complete read |

## Verification
Result acceptance and the start of a host frame can land in the same `clk` cycle. The bench drives chip select low one cycle before it raises `res_valid`, so that the handshake happens on the very edge where the synchronised select becomes active. During that frame it also drives all ones on the host data line. The outcome is judged in two ways: the frame must deliver the new word bit-exactly as a read, and a later conversion must still show an offset of zero, which proves no write took place.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int unsigned RSP_MAG_W  = 14;
  localparam int unsigned RSP_SYNC_N = 2;
  localparam logic [2:0]  RSP_PIN_IDLE = 3'b010; // {mosi, cs_n, sck}
endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsp_offset_sub.sv
module rsp_offset_sub #(
  parameter int unsigned MAG_W = 14
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             neg_i,
  input  logic             ovr_i,
  input  logic [MAG_W+1:0] ofs_i,
  output logic [MAG_W+1:0] word_o,
  output logic             sat_o
);
  localparam int unsigned W  = MAG_W + 2;
  localparam int unsigned DW = W + 1;
  localparam int HI_I = (1 << MAG_W) - 1;
  localparam logic signed [DW-1:0] HI = DW'(HI_I);
  localparam logic signed [DW-1:0] LO = DW'(-HI_I - 1);

  logic signed [DW-1:0] mag_s, val_s, dif_s, clip_s;

  assign mag_s = $signed({{(DW-MAG_W){1'b0}}, mag_i});
  assign val_s = neg_i ? -mag_s : mag_s;
  assign dif_s = val_s - $signed({ofs_i[W-1], ofs_i});

  always_comb begin
    sat_o  = 1'b0;
    clip_s = dif_s;
    if (dif_s > HI) begin
      clip_s = HI;
      sat_o  = 1'b1;
    end else if (dif_s < LO) begin
      clip_s = LO;
      sat_o  = 1'b1;
    end
  end

  assign word_o = {ovr_i | sat_o, clip_s[W-2:0]};
endmodule

// File: rtl/rsp_ofs_rx.sv
module rsp_ofs_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         rise_i,
  input  logic         bit_i,
  input  logic         frame_end_i,
  output logic [W-1:0] ofs_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rx_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      cnt_q <= '0;
      ofs_q <= '0;
    end else if (frame_end_i) begin
      cnt_q <= '0;
    end else if (en_i && rise_i && (cnt_q < CW'(W))) begin
      rx_q  <= {bit_i, rx_q[W-1:1]};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) ofs_q <= {bit_i, rx_q[W-1:1]};
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/adc_spi_readout.sv
module adc_spi_readout
  import rsp_pkg::*;
#(
  parameter int unsigned MAG_W  = RSP_MAG_W,
  parameter int unsigned SYNC_N = RSP_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [MAG_W-1:0] res_mag,
  input  logic             res_neg,
  input  logic             res_ovr,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             read_done
);
  localparam int unsigned W  = MAG_W + 2;
  localparam int unsigned CW = $clog2(W + 1);

  // pin synchronisers: index 0 sck, 1 cs_n, 2 mosi
  logic [2:0] pin_raw, pin_s;
  assign pin_raw = {spi_mosi, spi_cs_n, spi_sck};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    rsp_sync #(.STAGES(SYNC_N), .RST_VAL(RSP_PIN_IDLE[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_raw[g]),
      .q_o  (pin_s[g])
    );
  end

  logic sck_d, cs_act, cs_act_d;
  logic sck_rise, sck_fall, cs_end;

  assign cs_act = ~pin_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cs_act_d <= 1'b0;
    end else begin
      sck_d    <= pin_s[0];
      cs_act_d <= cs_act;
    end
  end

  assign sck_rise = pin_s[0] & ~sck_d;
  assign sck_fall = ~pin_s[0] & sck_d;
  assign cs_end   = cs_act_d & ~cs_act;

  // offset correction
  logic [W-1:0] ofs_val, word_nx;
  logic         sat_nx;

  rsp_offset_sub #(.MAG_W(MAG_W)) u_sub (
    .mag_i (res_mag),
    .neg_i (res_neg),
    .ovr_i (res_ovr),
    .ofs_i (ofs_val),
    .word_o(word_nx),
    .sat_o (sat_nx)
  );

  // transmit path
  logic          loaded_q, done_q;
  logic [W-1:0]  shreg_q, held_q;
  logic [CW-1:0] bit_cnt_q;
  logic          res_fire;

  assign res_ready = ~loaded_q & ~cs_act;
  assign res_fire  = res_valid & res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      done_q    <= 1'b0;
      shreg_q   <= '0;
      held_q    <= '0;
      bit_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (res_fire) begin
        shreg_q   <= word_nx;
        held_q    <= word_nx;
        loaded_q  <= 1'b1;
        bit_cnt_q <= '0;
      end else if (loaded_q) begin
        if (cs_end) begin
          shreg_q   <= held_q;
          bit_cnt_q <= '0;
        end else if (cs_act && sck_fall) begin
          shreg_q <= shreg_q >> 1;
          if (bit_cnt_q == CW'(W - 1)) begin
            loaded_q  <= 1'b0;
            done_q    <= 1'b1;
            bit_cnt_q <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign spi_miso  = loaded_q & shreg_q[0];
  assign read_done = done_q;

  // receive path for offset writes
  rsp_ofs_rx #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cs_act & ~loaded_q),
    .rise_i     (sck_rise),
    .bit_i      (pin_s[2]),
    .frame_end_i(cs_end),
    .ofs_o      (ofs_val)
  );
endmodule

// File: rtl/adc_spi_readout_chk.sv
module adc_spi_readout_chk #(
  parameter int unsigned MAG_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic             cs_act,
  input logic             sat_nx,
  input logic [MAG_W+1:0] word_nx,
  input logic [MAG_W+1:0] ofs_val,
  input logic             spi_miso,
  input logic             read_done
);
  localparam int unsigned W = MAG_W + 2;
  localparam logic [W-2:0] HI15 = {1'b0, {MAG_W{1'b1}}};
  localparam logic [W-2:0] LO15 = {1'b1, {MAG_W{1'b0}}};

  p_lsb_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (spi_miso == $past(word_nx[0])));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done);

  p_sat_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_nx |-> ((word_nx[W-2:0] == HI15) || (word_nx[W-2:0] == LO15)));

  p_sat_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_nx |-> word_nx[W-1]);

  p_ready_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> !res_ready);

  p_ofs_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_val != $past(ofs_val)) |-> $past(cs_act));
endmodule

bind adc_spi_readout adc_spi_readout_chk #(.MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .cs_act   (cs_act),
  .sat_nx   (sat_nx),
  .word_nx  (word_nx),
  .ofs_val  (ofs_val),
  .spi_miso (spi_miso),
  .read_done(read_done)
);

// File: tb/adc_spi_readout_bench.sv
module adc_spi_readout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [13:0] res_mag = '0;
  logic res_neg = 1'b0;
  logic res_ovr = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic read_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_spi_readout u_adc_spi_readout (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_mag(res_mag), .res_neg(res_neg), .res_ovr(res_ovr),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .read_done(read_done)
  );

  int n_chk = 0;
  int n_err = 0;
  int done_cnt = 0;
  int ofs_model = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  event got_ev;

  always @(posedge clk) if (rst_n && read_done) done_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sb_expect(input int mag, input bit neg, input bit ovr, input int ofs);
    int v;
    int d;
    bit s;
    v = neg ? -mag : mag;
    d = v - ofs;
    s = 1'b0;
    if (d > 16383) begin d = 16383; s = 1'b1; end
    else if (d < -16384) begin d = -16384; s = 1'b1; end
    return {ovr | s, d[14:0]};
  endfunction

  // monitor: compares every completed read against the scoreboard
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() != 0) begin
        logic [15:0] g;
        logic [15:0] e;
        g = got_q.pop_front();
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected word", g, 0);
        else begin
          e = exp_q.pop_front();
          check(g == e, "R1/R3 word read", g, e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offer one result, push its expected word
  task automatic convert(input int mag, input bit neg, input bit ovr);
    exp_q.push_back(sb_expect(mag, neg, ovr, ofs_model));
    res_mag = 14'(mag);
    res_neg = neg;
    res_ovr = ovr;
    res_valid = 1'b1;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    check(res_ready == 1'b0, "R5 ready low while word held", res_ready, 0);
    check(spi_miso == exp_q[exp_q.size()-1][0], "R2 LSB before any edge",
          spi_miso, exp_q[exp_q.size()-1][0]);
  endtask

  // one host frame; nbits clock pulses, mosi pattern LSB first
  task automatic frame(input int nbits, input logic [15:0] tx, input bit lower_cs,
                       output logic [15:0] rx);
    rx = '0;
    if (lower_cs) begin
      spi_cs_n = 1'b0;
      wait_clk(HALF);
    end
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic read_word();
    logic [15:0] rx;
    int d0;
    d0 = done_cnt;
    frame(16, 16'h0000, 1'b1, rx);
    got_q.push_back(rx);
    -> got_ev;
    check(done_cnt == d0 + 1, "R3 single read_done pulse", done_cnt - d0, 1);
    check(res_ready == 1'b1, "R5 ready after full read", res_ready, 1);
  endtask

  task automatic write_ofs(input logic [15:0] v, input int nbits);
    logic [15:0] rx;
    frame(nbits, v, 1'b1, rx);
    if (nbits == 16) ofs_model = int'($signed(v));
  endtask

  initial begin
    logic [15:0] rx;
    int d0;
    wait_clk(3);
    check(res_ready == 1'b1, "R8 ready after reset", res_ready, 1);
    check(spi_miso == 1'b0, "R8 miso after reset", spi_miso, 0);
    check(read_done == 1'b0, "R8 read_done after reset", read_done, 0);
    rst_n = 1'b1;
    wait_clk(3);

    // R8 offset zero, R1 positive and negative values
    convert(100, 1'b0, 1'b0);  read_word();
    convert(5, 1'b1, 1'b0);    read_word();
    convert(14'h1234, 1'b0, 1'b1); read_word();

    // R6 full offset write
    write_ofs(16'd10, 16);
    convert(100, 1'b0, 1'b0);  read_word();

    // R6 truncated write leaves offset
    write_ofs(16'h00FF, 8);
    convert(50, 1'b0, 1'b0);   read_word();

    // R7 abort and resend
    convert(77, 1'b1, 1'b0);
    d0 = done_cnt;
    frame(5, 16'h0000, 1'b1, rx);
    check(done_cnt == d0, "R7 no read_done on abort", done_cnt - d0, 0);
    check(res_ready == 1'b0, "R7 word still held", res_ready, 0);
    check(spi_miso == exp_q[0][0], "R7 LSB restored", spi_miso, exp_q[0][0]);
    read_word();

    // R4 saturation both ways
    write_ofs(16'h8000, 16);
    convert(16383, 1'b0, 1'b0); read_word();
    write_ofs(16'd16383, 16);
    convert(16383, 1'b1, 1'b0); read_word();
    write_ofs(16'd0, 16);
    convert(1, 1'b0, 1'b0);    read_word();

    // R5/R6 acceptance on the edge where the frame starts
    spi_cs_n = 1'b0;
    wait_clk(1);
    exp_q.push_back(sb_expect(321, 1'b0, 1'b0, ofs_model));
    res_mag = 14'd321; res_neg = 1'b0; res_ovr = 1'b0;
    res_valid = 1'b1;
    wait_clk(1);
    res_valid = 1'b0;
    check(res_ready == 1'b0, "R5 accepted at frame start", res_ready, 0);
    d0 = done_cnt;
    frame(16, 16'hFFFF, 1'b0, rx);
    got_q.push_back(rx);
    -> got_ev;
    check(done_cnt == d0 + 1, "R3 read_done on coincident frame", done_cnt - d0, 1);
    convert(3, 1'b0, 1'b0);    read_word();  // R6 offset must still be 0

    wait_clk(4);
    check(exp_q.size() == 0, "R1 all expected words read", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule